// File: doc/BRIEF.md
# Slew-Rate Limited Temperature Reporter

The block turns a stream of raw temperature samples into a smoothed reported temperature. Both values are 11-bit unsigned numbers in eighths of a degree Celsius. The reported value moves toward the latest sample one LSB (0.125 °C) at a time. A step is taken only after the sample has stayed on one side of the reported value for a programmed number of time-base ticks. Rising and falling steps each have their own dwell time. A rise larger than a programmed margin is applied in one go. Downward slewing can be switched off, and the reported value then drops to a lower sample at once.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `meas_ready` is low only while reset is applied and for the first clock after it, and is high from then on. A sample is accepted on every clock edge where `meas_valid` and `meas_ready` are both high. An accepted sample replaces the previous one, and the slew logic always works on the most recent accepted sample. Configuration is a plain 13-bit word loaded by a one-cycle write strobe. The `tick` input sets the time base for the dwell counting.

Top module: `temp_slew_reporter`

## Requirements
- R1: The configuration word loaded by `cfg_wr` has this layout: bits 4:0 hold the up step time and bits 12:8 hold the down step time, both counted in ticks. Bits 6:5 hold the up-jump code and bit 7 enables down slewing. A written word takes effect from the clock after the write, and reset clears it to all zero.
- R2: After reset `rpt_temp` is 0 and `rpt_valid` is 0. The first accepted sample is copied into `rpt_temp` on that same edge, and `rpt_valid` is then 1.
- R3: `meas_ready` is 0 during reset and 1 from the second edge after reset is released. Each accepted sample replaces the one held before.
- R4: While the held sample is above `rpt_temp` by no more than the jump margin, `rpt_temp` rises by exactly 1 once the up step time has elapsed in counted ticks. A step time of 0 counts as 1 tick.
- R5: With down slewing enabled, while the held sample is below `rpt_temp`, `rpt_temp` falls by exactly 1 once the down step time has elapsed in counted ticks. A step time of 0 counts as 1 tick.
- R6: When the held sample exceeds `rpt_temp` by more than 8, 16, 32 or 64 LSB, `rpt_temp` takes the held sample on the next edge. The margin is chosen by up-jump code 0, 1, 2 or 3, which stands for 1, 2, 4 or 8 °C. A difference equal to the margin slews.
- R7: With down slewing disabled, a held sample below `rpt_temp` is copied into `rpt_temp` on the next edge.
- R8: The dwell count restarts when the held sample becomes equal to `rpt_temp`, or moves to the other side of it. A tick in the cycle of such a change is not counted.
- R9: `rpt_temp` holds in any cycle without `tick`, unless a jump or a non-slewed drop applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the configuration word |
| cfg_data | input | 13 | Configuration word (layout in R1) |
| tick | input | 1 | Time-base pulse for dwell counting |
| meas_valid | input | 1 | Sample valid |
| meas_ready | output | 1 | Sample ready (no back-pressure after reset) |
| meas_temp | input | 11 | Raw sample, 1/8 °C per LSB |
| rpt_valid | output | 1 | Reported value has been loaded |
| rpt_temp | output | 11 | Reported temperature, 1/8 °C per LSB |

## Verification
Directed sequences each test one behaviour:
- A small rise under a three-tick up time, with idle cycles in between, separates counted ticks from plain clocks.
- Rises of exactly the margin and of far more than the margin separate slewing from an immediate jump.
- A drop with slewing on, then the same drop with slewing off, separates the two down modes.
- A zero step time shows that zero counts as one tick.
- A count interrupted by an equal sample shows whether the dwell restarts.

Random samples near and far from the reported value are then mixed with random ticks and random configuration writes. Every cycle is compared against a reference model built from the requirements.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // relation of the held sample to the reported value
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_UP = 2'd1,
    REL_DN = 2'd2
  } rel_e;
endpackage

// File: rtl/tsr_cfg_reg.sv
module tsr_cfg_reg #(
  parameter int STEP_W = 5,
  localparam int CFG_W = 2 * STEP_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_W-1:0]  data,
  output logic [STEP_W-1:0] up_lim,
  output logic [STEP_W-1:0] dn_lim,
  output logic [1:0]        jump_code,
  output logic              dn_en
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= data;
  end

  logic [STEP_W-1:0] up_raw, dn_raw;
  assign up_raw    = cfg_q[STEP_W-1:0];
  assign jump_code = cfg_q[STEP_W+1:STEP_W];
  assign dn_en     = cfg_q[STEP_W+2];
  assign dn_raw    = cfg_q[CFG_W-1:STEP_W+3];

  // a zero step time behaves as one tick (R4, R5)
  assign up_lim = (up_raw == '0) ? STEP_W'(1) : up_raw;
  assign dn_lim = (dn_raw == '0) ? STEP_W'(1) : dn_raw;

  assert_lim_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_lim != '0) && (dn_lim != '0));
endmodule

// File: rtl/tsr_sample_in.sv
module tsr_sample_in #(
  parameter int TEMP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [TEMP_W-1:0] temp,
  output logic              ready,
  output logic [TEMP_W-1:0] held,
  output logic              primed,
  output logic              load_first
);
  logic accept;
  assign accept     = valid && ready;
  assign load_first = accept && !primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      held   <= '0;
      primed <= 1'b0;
    end else begin
      ready <= 1'b1;
      if (accept) begin
        held   <= temp;
        primed <= 1'b1;
      end
    end
  end

  assert_latest_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid && ready) |-> (held == $past(temp)));
endmodule

// File: rtl/tsr_dwell.sv
module tsr_dwell #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [STEP_W-1:0] lim,
  output logic              step
);
  logic [STEP_W-1:0] cnt;
  logic [STEP_W:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign step = tick && !clear && (nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clear || step) cnt <= '0;
    else if (tick)          cnt <= nxt[STEP_W-1:0];
  end

  // R8: a count never survives a restart
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) && !tick |-> (cnt == '0));
endmodule

// File: rtl/tsr_slew_core.sv
module tsr_slew_core
  import tsr_pkg::*;
#(
  parameter int TEMP_W    = 11,
  parameter int STEP_W    = 5,
  parameter int FRAC_BITS = 3,
  localparam int THR_W    = TEMP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primed,
  input  logic              load_first,
  input  logic [TEMP_W-1:0] first_temp,
  input  logic [TEMP_W-1:0] held,
  input  logic              tick,
  input  logic [STEP_W-1:0] up_lim,
  input  logic [STEP_W-1:0] dn_lim,
  input  logic [1:0]        jump_code,
  input  logic              dn_en,
  output logic [TEMP_W-1:0] tctl
);
  localparam logic [THR_W-1:0] ONE_DEG = THR_W'(1) << FRAC_BITS;

  rel_e              rel, rel_q;
  logic [TEMP_W-1:0] diff_up;
  logic [THR_W-1:0]  thr;
  logic              jump, drop_now, step, clear;
  logic [STEP_W-1:0] lim;

  always_comb begin
    if (held > tctl)      rel = REL_UP;
    else if (held < tctl) rel = REL_DN;
    else                  rel = REL_EQ;
  end

  assign diff_up  = held - tctl;
  assign thr      = ONE_DEG << jump_code;
  assign jump     = (rel == REL_UP) && ({{(THR_W-TEMP_W){1'b0}}, diff_up} > thr);
  assign drop_now = (rel == REL_DN) && !dn_en;
  assign lim      = (rel == REL_DN) ? dn_lim : up_lim;
  assign clear    = !primed || load_first || (rel == REL_EQ) || (rel != rel_q)
                    || jump || drop_now;

  tsr_dwell #(.STEP_W(STEP_W)) u_dwell (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .tick (tick),
    .lim  (lim),
    .step (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tctl  <= '0;
      rel_q <= REL_EQ;
    end else if (load_first) begin
      tctl  <= first_temp;
      rel_q <= REL_EQ;
    end else if (primed) begin
      rel_q <= rel;
      unique case (rel)
        REL_UP: begin
          if (jump)      tctl <= held;
          else if (step) tctl <= tctl + 1'b1;
        end
        REL_DN: begin
          if (drop_now)  tctl <= held;
          else if (step) tctl <= tctl - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_reset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (tctl == '0));

  // R4 and R5: any change that is not a copy is a single LSB on a tick
  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && (tctl != $past(tctl)) && (tctl != $past(held)))
      |-> ($past(tick) && ((tctl == $past(tctl) + 1'b1) || (tctl == $past(tctl) - 1'b1))));

  assert_big_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed && (held > tctl) && ({4'b0, held - tctl} > (ONE_DEG << jump_code)))
      |-> (tctl == $past(held)));

  assert_no_down_slew_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed && (held < tctl) && !dn_en) |-> (tctl == $past(held)));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed && !tick && (held >= tctl)
          && ({4'b0, held - tctl} <= (ONE_DEG << jump_code)))
      |-> (tctl == $past(tctl)));
endmodule

// File: rtl/temp_slew_reporter.sv
module temp_slew_reporter #(
  parameter int TEMP_W    = 11,
  parameter int STEP_W    = 5,
  parameter int FRAC_BITS = 3,
  localparam int CFG_W    = 2 * STEP_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              tick,
  input  logic              meas_valid,
  output logic              meas_ready,
  input  logic [TEMP_W-1:0] meas_temp,
  output logic              rpt_valid,
  output logic [TEMP_W-1:0] rpt_temp
);
  logic [STEP_W-1:0] up_lim, dn_lim;
  logic [1:0]        jump_code;
  logic              dn_en, primed, load_first;
  logic [TEMP_W-1:0] held;

  tsr_cfg_reg #(.STEP_W(STEP_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .data     (cfg_data),
    .up_lim   (up_lim),
    .dn_lim   (dn_lim),
    .jump_code(jump_code),
    .dn_en    (dn_en)
  );

  tsr_sample_in #(.TEMP_W(TEMP_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (meas_valid),
    .temp      (meas_temp),
    .ready     (meas_ready),
    .held      (held),
    .primed    (primed),
    .load_first(load_first)
  );

  tsr_slew_core #(.TEMP_W(TEMP_W), .STEP_W(STEP_W), .FRAC_BITS(FRAC_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .primed    (primed),
    .load_first(load_first),
    .first_temp(meas_temp),
    .held      (held),
    .tick      (tick),
    .up_lim    (up_lim),
    .dn_lim    (dn_lim),
    .jump_code (jump_code),
    .dn_en     (dn_en),
    .tctl      (rpt_temp)
  );

  assign rpt_valid = primed;

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rpt_valid) |-> rpt_valid);
endmodule

// File: tb/temp_slew_reporter_test.sv
`timescale 1ns/1ps
module temp_slew_reporter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [12:0] cfg_data = '0;
  logic        tick = 1'b0;
  logic        meas_valid = 1'b0;
  logic        meas_ready;
  logic [10:0] meas_temp = '0;
  logic        rpt_valid;
  logic [10:0] rpt_temp;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  temp_slew_reporter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .tick(tick),
    .meas_valid(meas_valid), .meas_ready(meas_ready), .meas_temp(meas_temp),
    .rpt_valid(rpt_valid), .rpt_temp(rpt_temp)
  );

  // reference model built from the requirements
  int m_cfg, m_held, m_tctl, m_cnt, m_rel_q;
  bit m_primed, m_ready;

  function automatic int lim_of(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  always @(posedge clk) begin
    int rel, up_t, dn_t, code, thr;
    bit den, acc, clr, stp;
    if (!rst_n) begin
      m_cfg = 0; m_held = 0; m_tctl = 0; m_cnt = 0; m_rel_q = 0;
      m_primed = 0; m_ready = 0;
    end else begin
      up_t = lim_of(m_cfg & 31);
      code = (m_cfg >> 5) & 3;
      den  = (m_cfg >> 7) & 1;
      dn_t = lim_of((m_cfg >> 8) & 31);
      thr  = 8 << code;
      acc  = meas_valid && m_ready;
      if (acc && !m_primed) begin
        m_tctl = meas_temp; m_rel_q = 0; m_cnt = 0; m_primed = 1;
      end else if (m_primed) begin
        rel = (m_held > m_tctl) ? 1 : (m_held < m_tctl) ? 2 : 0;
        clr = (rel == 0) || (rel != m_rel_q);
        stp = 0;
        if (rel == 1 && (m_held - m_tctl) > thr) begin
          m_tctl = m_held; clr = 1;
        end else if (rel == 2 && !den) begin
          m_tctl = m_held; clr = 1;
        end else if (!clr && tick) begin
          if (m_cnt + 1 >= ((rel == 2) ? dn_t : up_t)) stp = 1;
          else m_cnt = m_cnt + 1;
          if (stp) m_tctl = (rel == 1) ? m_tctl + 1 : m_tctl - 1;
        end
        if (clr || stp) m_cnt = 0;
        m_rel_q = rel;
      end
      if (acc) m_held = meas_temp;
      if (cfg_wr) m_cfg = cfg_data;
      m_ready = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive after a falling edge, compare at the next falling edge
  task automatic cyc(input bit v, input int t, input bit tk, input bit w, input int c);
    meas_valid = v; meas_temp = 11'(t); tick = tk; cfg_wr = w; cfg_data = 13'(c);
    @(posedge clk);
    @(negedge clk);
    meas_valid = 0; tick = 0; cfg_wr = 0;
    chk(cur_req, rpt_temp, m_tctl);
    chk(cur_req, rpt_valid, m_primed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R2", rpt_temp, 0);
    chk("R2", rpt_valid, 0);
    chk("R3", meas_ready, 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R3", meas_ready, 1);
    // R1 layout: up 3, code 0, down slew on, down 2
    cur_req = "R1";
    cyc(0, 0, 0, 1, 13'h283);
    cur_req = "R2";
    cyc(1, 100, 0, 0, 0);  chk("R2", rpt_temp, 100); chk("R2", rpt_valid, 1);
    cur_req = "R4";
    cyc(1, 102, 0, 0, 0);  chk("R4", rpt_temp, 100);
    cyc(0, 0, 1, 0, 0);    // direction change, tick not counted
    cyc(0, 0, 1, 0, 0);    // count 1
    cyc(0, 0, 0, 0, 0);    chk("R9", rpt_temp, 100);
    cyc(0, 0, 1, 0, 0);    chk("R4", rpt_temp, 100);
    cyc(0, 0, 1, 0, 0);    chk("R4", rpt_temp, 101);
    cur_req = "R6";
    cyc(1, 200, 0, 0, 0);  chk("R9", rpt_temp, 101);
    cyc(0, 0, 0, 0, 0);    chk("R6", rpt_temp, 200);
    cyc(1, 208, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);    chk("R6", rpt_temp, 200);
    cur_req = "R5";
    cyc(1, 190, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);    chk("R5", rpt_temp, 200);
    cyc(0, 0, 1, 0, 0);    chk("R5", rpt_temp, 199);
    cur_req = "R7";
    cyc(0, 0, 0, 1, 13'h003);
    cyc(0, 0, 0, 0, 0);    chk("R7", rpt_temp, 190);
    cur_req = "R4";
    cyc(0, 0, 0, 1, 13'h080);
    cyc(1, 191, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);    chk("R4", rpt_temp, 190);
    cyc(0, 0, 1, 0, 0);    chk("R4", rpt_temp, 191);
    cur_req = "R8";
    cyc(0, 0, 0, 1, 13'h283);
    cyc(1, 195, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);    // count 1
    cyc(1, 191, 0, 0, 0);  chk("R3", meas_ready, 1);
    cyc(0, 0, 1, 0, 0);    // equal: restart
    cyc(1, 195, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);    chk("R8", rpt_temp, 191);
    cyc(0, 0, 1, 0, 0);    chk("R8", rpt_temp, 192);
    // random phase, compared against the model every cycle
    cur_req = "R5";
    for (int i = 0; i < 6000; i++) begin
      int t, c;
      bit v, tk, w;
      v  = ($urandom_range(0, 7) == 0);
      tk = ($urandom_range(0, 2) == 0);
      w  = ($urandom_range(0, 150) == 0);
      c  = $urandom_range(0, 8191) & 13'h1CE7;
      if ($urandom_range(0, 9) == 0) t = $urandom_range(0, 2047);
      else begin
        t = m_tctl + $urandom_range(0, 40) - 20;
        if (t < 0) t = 0;
        if (t > 2047) t = 2047;
      end
      cyc(v, t, tk, w, c);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule